// File: doc/BRIEF.md
# Multi-Bank Selectable Clock Divider

This block derives four divided clocks from one fast source clock: three bank clocks and one feedback clock. Each bank picks between a divide-by-2 and a divide-by-4 ratio with its own select bit. The feedback clock picks between divide-by-8 and divide-by-12. All four waveforms come from one shared phase counter, so their rising edges always coincide where their periods overlap. Every ratio is even, so every output has an exact 50% duty cycle.

Ratio selects are asynchronous to the fast clock. They pass through a two-stage synchronizer and take effect only at the wrap of a 24-cycle frame, which is the least common multiple of all ratios. This keeps every pulse at a width of the old ratio or of the new one. An input multiplexer picks one of two reference inputs. In static-test bypass, the picked reference is sent straight to all four outputs in place of the divided waveforms. An output-disable control turns off the drive-enable bits of the three banks. The feedback output keeps its enable set and keeps toggling. The pad tristate is modelled as a data bit plus a drive-enable bit for each output.

Top module: `multi_bank_clkdiv`

## Requirements
- R1: With bank select bit i at 0, bank_clk[i] has a period of 2 fast cycles and a high time of 1. With the bit at 1, the period is 4 and the high time is 2.
- R2: With fb_ratio at 0, fb_clk has a period of 8 fast cycles and a high time of 4. With fb_ratio at 1, the period is 12 and the high time is 6.
- R3: Reset is synchronous and active high. While it is applied, all data bits and all drive-enable bits are 0 one edge after it is sampled.
- R4: On the first clock edge after reset is released, all four data outputs go high together.
- R5: Every rising edge of fb_clk coincides with a rising edge of every bank clock.
- R6: With out_dis at 1, all bits of bank_drv are 0 one cycle later. fb_drv stays 1 and fb_clk keeps toggling. With out_dis at 0, every drive-enable bit is 1 one cycle later. out_dis does not change the data bits.
- R7: ref_pick at 0 selects ref_a and ref_pick at 1 selects ref_b. The input that is not selected has no effect.
- R8: With bypass_en at 1, all four data outputs equal the selected reference, sampled one fast cycle earlier.
- R9: A new ratio select takes effect only on the first edge after the 24-cycle frame wraps, once it has passed two synchronizer stages. Frame phase 0 is the first edge after reset. During a switch, every bank pulse lasts 1 or 2 cycles and every feedback pulse lasts 4 or 6 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_a | input | 1 | Single-ended reference level |
| ref_b | input | 1 | Received differential reference level |
| ref_pick | input | 1 | Reference select: 0 ref_a, 1 ref_b |
| bypass_en | input | 1 | Static-test bypass: outputs follow the selected reference |
| out_dis | input | 1 | 1 turns off the bank drive-enables |
| bank_ratio | input | 3 | Per-bank ratio select: 0 divide-by-2, 1 divide-by-4 |
| fb_ratio | input | 1 | Feedback ratio select: 0 divide-by-8, 1 divide-by-12 |
| bank_clk | output | 3 | Bank clock data bits |
| bank_drv | output | 3 | Bank drive-enable bits |
| fb_clk | output | 1 | Feedback clock data bit |
| fb_drv | output | 1 | Feedback drive-enable bit |

## Verification
A corrupted phase counter shows up as a bank edge missing at a feedback rise, or as a pulse of an illegal width. This becomes visible within one feedback period, at most 12 cycles. A select register that updates away from the frame wrap produces a pulse of 3 cycles, or of some other width outside the legal set. It also breaks the exact bank-0 waveform that is followed across the first frame after reset. A stuck drive-enable or bypass path shows up at the ports one cycle after the control changes.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
  function automatic int gcd_i(input int a, input int b);
    int x;
    int y;
    int t;
    x = a;
    y = b;
    while (y != 0) begin
      t = x % y;
      x = y;
      y = t;
    end
    return x;
  endfunction

  function automatic int lcm_i(input int a, input int b);
    return (a / gcd_i(a, b)) * b;
  endfunction
endpackage

// File: rtl/cdiv_sync.sv
module cdiv_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/cdiv_phase.sv
module cdiv_phase #(
  parameter int LEN = 24,
  parameter int PW  = 5
) (
  input  logic          clk,
  input  logic          rst,
  output logic [PW-1:0] phase,
  output logic          boundary
);
  localparam logic [PW-1:0] LAST = PW'(LEN - 1);

  assign boundary = (phase == LAST);

  always_ff @(posedge clk) begin
    if (rst)           phase <= '0;
    else if (boundary) phase <= '0;
    else               phase <= phase + 1'b1;
  end
endmodule

// File: rtl/cdiv_wave.sv
module cdiv_wave #(
  parameter int DIV_LO = 2,
  parameter int DIV_HI = 4,
  parameter int PW     = 5
) (
  input  logic [PW-1:0] phase,
  input  logic          hi_sel,
  output logic          level
);
  localparam int HALF_LO = DIV_LO / 2;
  localparam int HALF_HI = DIV_HI / 2;

  int ph;

  always_comb begin
    ph = int'(phase);
    if (hi_sel) level = (ph % DIV_HI) < HALF_HI;
    else        level = (ph % DIV_LO) < HALF_LO;
  end
endmodule

// File: rtl/multi_bank_clkdiv.sv
module multi_bank_clkdiv #(
  parameter int NUM_BANKS   = 3,
  parameter int BANK_DIV_LO = 2,
  parameter int BANK_DIV_HI = 4,
  parameter int FB_DIV_LO   = 8,
  parameter int FB_DIV_HI   = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ref_a,
  input  logic                 ref_b,
  input  logic                 ref_pick,
  input  logic                 bypass_en,
  input  logic                 out_dis,
  input  logic [NUM_BANKS-1:0] bank_ratio,
  input  logic                 fb_ratio,
  output logic [NUM_BANKS-1:0] bank_clk,
  output logic [NUM_BANKS-1:0] bank_drv,
  output logic                 fb_clk,
  output logic                 fb_drv
);
  localparam int FRAME = cdiv_pkg::lcm_i(cdiv_pkg::lcm_i(BANK_DIV_LO, BANK_DIV_HI),
                                         cdiv_pkg::lcm_i(FB_DIV_LO, FB_DIV_HI));
  localparam int PW = (FRAME > 1) ? $clog2(FRAME) : 1;
  localparam int SW = NUM_BANKS + 1;

  logic [SW-1:0]        sel_sync;
  logic [SW-1:0]        sel_live;
  logic [PW-1:0]        phase;
  logic                 boundary;
  logic [NUM_BANKS-1:0] bank_lvl;
  logic                 fb_lvl;
  logic                 ref_mux;

  cdiv_sync #(.W(SW)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({fb_ratio, bank_ratio}),
    .q   (sel_sync)
  );

  cdiv_phase #(.LEN(FRAME), .PW(PW)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .phase    (phase),
    .boundary (boundary)
  );

  // ratio selects change only at the frame wrap
  always_ff @(posedge clk) begin
    if (rst)           sel_live <= '0;
    else if (boundary) sel_live <= sel_sync;
  end

  generate
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
      cdiv_wave #(.DIV_LO(BANK_DIV_LO), .DIV_HI(BANK_DIV_HI), .PW(PW)) u_wave (
        .phase  (phase),
        .hi_sel (sel_live[g]),
        .level  (bank_lvl[g])
      );
    end
  endgenerate

  cdiv_wave #(.DIV_LO(FB_DIV_LO), .DIV_HI(FB_DIV_HI), .PW(PW)) u_fb_wave (
    .phase  (phase),
    .hi_sel (sel_live[SW-1]),
    .level  (fb_lvl)
  );

  assign ref_mux = ref_pick ? ref_b : ref_a;

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_clk <= '0;
      fb_clk   <= 1'b0;
      bank_drv <= '0;
      fb_drv   <= 1'b0;
    end else begin
      bank_clk <= bypass_en ? {NUM_BANKS{ref_mux}} : bank_lvl;
      fb_clk   <= bypass_en ? ref_mux : fb_lvl;
      bank_drv <= {NUM_BANKS{~out_dis}};
      fb_drv   <= 1'b1;
    end
  end

  p_switch_boundary_r9: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> $stable(sel_live));

  p_align_r5: assert property (@(posedge clk) disable iff (rst)
    (phase == '0) && !bypass_en |=> (bank_clk == {NUM_BANKS{1'b1}}) && fb_clk);

  p_fb_exempt_r6: assert property (@(posedge clk) disable iff (rst)
    out_dis |=> (bank_drv == '0) && fb_drv);

  p_bypass_follow_r8: assert property (@(posedge clk) disable iff (rst)
    bypass_en |=> (fb_clk == $past(ref_mux)) && (bank_clk == {NUM_BANKS{$past(ref_mux)}}));

  p_reset_rise_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) && !bypass_en |-> ##1 ((bank_clk == {NUM_BANKS{1'b1}}) && fb_clk));
endmodule

// File: tb/sim_multi_bank_clkdiv.sv
module sim_multi_bank_clkdiv;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = 48;

  typedef struct {
    int per [4];
    int hi  [4];
  } exp_t;

  logic       clk = 1'b0;
  logic       rst;
  logic       ref_a, ref_b, ref_pick, bypass_en, out_dis, fb_ratio;
  logic [2:0] bank_ratio;
  logic [2:0] bank_clk, bank_drv;
  logic       fb_clk, fb_drv;

  int   n_checks = 0;
  int   n_fail   = 0;
  int   cyc      = 0;
  bit   track_en = 1'b0;
  bit   meas_go  = 1'b0;
  bit   meas_done = 1'b0;
  bit   finished = 1'b0;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  multi_bank_clkdiv u0 (
    .clk(clk), .rst(rst), .ref_a(ref_a), .ref_b(ref_b), .ref_pick(ref_pick),
    .bypass_en(bypass_en), .out_dis(out_dis), .bank_ratio(bank_ratio),
    .fb_ratio(fb_ratio), .bank_clk(bank_clk), .bank_drv(bank_drv),
    .fb_clk(fb_clk), .fb_drv(fb_drv)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, expv, cyc);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // monitor: pulse legality, edge alignment, windowed period/high checks
  initial begin
    logic [3:0] prv;
    logic [3:0] v;
    int   last_t [4];
    bit   seen   [4];
    int   wrise  [4];
    exp_t cur;
    int   wcnt;
    bit   wact;
    prv  = '0;
    wact = 1'b0;
    wcnt = 0;
    for (int i = 0; i < 4; i++) begin
      last_t[i] = 0; seen[i] = 1'b0; wrise[i] = -1;
      cur.per[i] = 0; cur.hi[i] = 0;
    end
    forever begin
      @(negedge clk);
      cyc++;
      v = {fb_clk, bank_clk};
      if (!track_en) begin
        for (int i = 0; i < 4; i++) seen[i] = 1'b0;
      end else begin
        for (int i = 0; i < 4; i++) begin
          if (v[i] != prv[i]) begin
            if (seen[i]) begin
              int w;
              w = cyc - last_t[i];
              if (i < 3) chk((w == 1) || (w == 2), "R9", $sformatf("bank%0d pulse width", i), w, 2);
              else       chk((w == 4) || (w == 6), "R9", "fb pulse width", w, 6);
            end
            if (v[i]) seen[i] = 1'b1;
            last_t[i] = cyc;
          end
        end
        if (v[3] && !prv[3])
          chk((v[2:0] & ~prv[2:0]) == 3'b111, "R5", "bank rises at fb rise",
              int'(v[2:0] & ~prv[2:0]), 7);
      end
      if (meas_go && !wact && exp_q.size() > 0) begin
        cur     = exp_q.pop_front();
        meas_go = 1'b0;
        wact    = 1'b1;
        wcnt    = 0;
        for (int i = 0; i < 4; i++) wrise[i] = -1;
      end else if (wact) begin
        for (int i = 0; i < 4; i++) begin
          if (v[i] && !prv[i]) begin
            if (wrise[i] >= 0)
              chk(cyc - wrise[i] == cur.per[i], (i < 3) ? "R1" : "R2",
                  $sformatf("period of output %0d", i), cyc - wrise[i], cur.per[i]);
            wrise[i] = cyc;
          end else if (!v[i] && prv[i] && wrise[i] >= 0) begin
            chk(cyc - wrise[i] == cur.hi[i], (i < 3) ? "R1" : "R2",
                $sformatf("high time of output %0d", i), cyc - wrise[i], cur.hi[i]);
          end
        end
        wcnt++;
        if (wcnt == WIN) begin
          wact      = 1'b0;
          meas_done = 1'b1;
        end
      end
      prv = v;
    end
  end

  // driver: applies a select combination and queues the expected waveform
  task automatic run_combo(input int c);
    exp_t e;
    @(negedge clk);
    bank_ratio = 3'(c);
    fb_ratio   = c[3];
    repeat (30) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      e.per[i] = c[i] ? 4 : 2;
      e.hi[i]  = e.per[i] / 2;
    end
    e.per[3] = c[3] ? 12 : 8;
    e.hi[3]  = e.per[3] / 2;
    exp_q.push_back(e);
    meas_done = 1'b0;
    meas_go   = 1'b1;
    wait (meas_done);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int toggles;
    logic last_fb;
    rst = 1'b1; ref_a = 1'b0; ref_b = 1'b0; ref_pick = 1'b0;
    bypass_en = 1'b0; out_dis = 1'b0; bank_ratio = 3'b000; fb_ratio = 1'b0;
    repeat (3) @(negedge clk);
    // R3: reset state
    chk(bank_clk == 3'b000 && fb_clk == 1'b0, "R3", "data in reset", int'({fb_clk, bank_clk}), 0);
    chk(bank_drv == 3'b000 && fb_drv == 1'b0, "R3", "drive in reset", int'({fb_drv, bank_drv}), 0);
    rst = 1'b0;
    @(negedge clk);
    // R4: first edge after release, every output high
    chk(bank_clk == 3'b111 && fb_clk, "R4", "outputs after release", int'({fb_clk, bank_clk}), 15);
    chk(bank_drv == 3'b111 && fb_drv, "R6", "drive enables with out_dis 0", int'({fb_drv, bank_drv}), 15);
    // R9: bank0 ratio request at frame phase 0; held until the frame wraps
    bank_ratio = 3'b001;
    track_en   = 1'b1;
    for (int j = 1; j <= 32; j++) begin
      @(negedge clk);
      if (j < 24) chk(bank_clk[0] == (j % 2 == 0), "R9", $sformatf("bank0 old ratio j=%0d", j),
                      int'(bank_clk[0]), int'(j % 2 == 0));
      else        chk(bank_clk[0] == ((j - 24) % 4 < 2), "R9", $sformatf("bank0 new ratio j=%0d", j),
                      int'(bank_clk[0]), int'((j - 24) % 4 < 2));
    end
    // R1, R2, R5: all sixteen select combinations
    for (int c = 0; c < 16; c++) run_combo(c);
    // R6: output disable spares the feedback output
    @(negedge clk);
    out_dis = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(bank_drv == 3'b000, "R6", "bank drive when disabled", int'(bank_drv), 0);
    chk(fb_drv == 1'b1, "R6", "fb drive when disabled", int'(fb_drv), 1);
    toggles = 0;
    last_fb = fb_clk;
    for (int k = 0; k < 24; k++) begin
      @(negedge clk);
      if (fb_clk != last_fb) toggles++;
      last_fb = fb_clk;
    end
    chk(toggles >= 2, "R6", "fb toggles while disabled", toggles, 2);
    out_dis = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(bank_drv == 3'b111 && fb_drv, "R6", "drive after re-enable", int'({fb_drv, bank_drv}), 15);
    // R7, R8: bypass with reference selection
    track_en  = 1'b0;
    bypass_en = 1'b1; ref_pick = 1'b0; ref_a = 1'b1; ref_b = 1'b0;
    @(negedge clk);
    chk({fb_clk, bank_clk} == 4'hF, "R8", "bypass ref_a high", int'({fb_clk, bank_clk}), 15);
    ref_a = 1'b0;
    @(negedge clk);
    chk({fb_clk, bank_clk} == 4'h0, "R8", "bypass ref_a low", int'({fb_clk, bank_clk}), 0);
    ref_pick = 1'b1; ref_b = 1'b1;
    @(negedge clk);
    chk({fb_clk, bank_clk} == 4'hF, "R7", "pick ref_b high", int'({fb_clk, bank_clk}), 15);
    ref_a = 1'b1; ref_b = 1'b0;
    @(negedge clk);
    chk({fb_clk, bank_clk} == 4'h0, "R7", "ref_a ignored when ref_b picked", int'({fb_clk, bank_clk}), 0);
    ref_pick = 1'b0;
    @(negedge clk);
    chk({fb_clk, bank_clk} == 4'hF, "R7", "ref_b ignored when ref_a picked", int'({fb_clk, bank_clk}), 15);
    bypass_en = 1'b0;
    repeat (2) @(negedge clk);
    track_en = 1'b1;
    run_combo(5);
    finish_run();
  end
endmodule